// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside the fetch stage of a small processor. Each time the core reaches an instruction boundary, the block looks at the device interrupt request. If a request is pending and interrupts are not masked, the block holds fetch off. It then runs a fixed five-step entry sequence:

- store the link register on the stack;
- move the stack pointer down one word;
- copy the interrupted program counter into the link register;
- read the handler address from a vector table;
- load that address into the program counter.

When the handler's return instruction completes, a second short sequence runs. It puts the link value back into the program counter, restores the old link register from the stack, and moves the stack pointer back up.

The block has one register-file write port, one memory port and one program-counter load port. It drives these one step per cycle. Memory reads return data one cycle after the read strobe, as a synchronous RAM does. The register file holds the stack pointer at index 5 and the link register at index 6.

Top module: `irq_entry_seq`

## Requirements
- R1: `fetch_en` is high only while the block is idle, `boundary` is high, and no entry or return sequence is starting in that cycle. It stays low on every cycle of both sequences.
- R2: An entry starts when `boundary` and `irq_flag` are both high, interrupts are unmasked and `iret` is low. On the next cycle the block raises `mem_we` with address `sp_val`−4 and data `link_val`, using the values sampled when the entry started.
- R3: On the second entry cycle the block writes register index 5 with the sampled `sp_val`−4.
- R4: On the third entry cycle the block writes register index 6 with the sampled `pc_cur`.
- R5: On the fourth entry cycle the block raises `mem_re` at address `vec_base` + 4×`irq_id`. On the fifth cycle it raises `pc_we` with `mem_rdata`, and a value of zero is loaded like any other.
- R6: Interrupts are masked from the start of entry until the return sequence ends. A request seen at a boundary while masked lets fetch proceed and starts nothing. If the request is still held once the mask clears, it is taken at the next boundary.
- R7: When `iret` is high in the idle state, the return sequence starts. On the next cycle the block raises `pc_we` with the sampled `link_val`. Then it raises `mem_re` at the sampled `sp_val`. Then it writes index 6 with `mem_rdata`. Then it writes index 5 with the sampled `sp_val`+4.
- R8: If `iret` and a takeable interrupt arrive in the same cycle, the return sequence runs and the entry does not.
- R9: After reset every strobe and `fetch_en` are low, and interrupts are unmasked.
- R10: At most one of `mem_we`, `mem_re`, `rf_we` and `pc_we` is high in any cycle.
- R11: `irq_flag` has no effect while `boundary` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary | input | 1 | Core is at an instruction boundary and wants to fetch |
| irq_flag | input | 1 | Device interrupt request |
| irq_id | input | IDW | Number of the requesting controller |
| vec_base | input | AW | Base address of the handler table |
| pc_cur | input | AW | Current program counter |
| sp_val | input | DW | Read value of the stack pointer register (index 5) |
| link_val | input | DW | Read value of the link register (index 6) |
| iret | input | 1 | Return-from-interrupt instruction completing |
| mem_rdata | input | DW | Memory read data, valid one cycle after `mem_re` |
| fetch_en | output | 1 | Permits the core to fetch |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | RFAW | Register-file write index |
| rf_wdata | output | DW | Register-file write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| pc_we | output | 1 | Program-counter load strobe |
| pc_wdata | output | AW | New program counter |

## Verification
The hardest state to reach is a request that arrives while entry has masked interrupts. That request must leave fetch running. It must then be taken only after the return sequence has finished. The bench enters a handler and keeps `irq_flag` high through a masked boundary. It then runs the return and checks that the same held request starts a fresh entry at the next boundary. A second hard case is `iret` and a takeable request arriving in the same cycle; the bench drives exactly that collision with the mask clear.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [3:0] {
    S_RUN,
    S_SAVE,
    S_ADJSP,
    S_LINK,
    S_VECRD,
    S_VECLD,
    S_RPC,
    S_RRD,
    S_RLINK,
    S_RSP
  } seq_state_t;
endpackage

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       boundary,
  input  logic       irq_flag,
  input  logic       iret,
  output seq_state_t state,
  output logic       masked,
  output logic       start_entry,
  output logic       start_ret
);
  seq_state_t state_n;

  // Return has priority over entry in the same cycle
  assign start_ret   = (state == S_RUN) && iret;
  assign start_entry = (state == S_RUN) && boundary && irq_flag && !masked && !iret;

  always_comb begin
    state_n = state;
    unique case (state)
      S_RUN: begin
        if (start_ret)        state_n = S_RPC;
        else if (start_entry) state_n = S_SAVE;
      end
      S_SAVE:  state_n = S_ADJSP;
      S_ADJSP: state_n = S_LINK;
      S_LINK:  state_n = S_VECRD;
      S_VECRD: state_n = S_VECLD;
      S_VECLD: state_n = S_RUN;
      S_RPC:   state_n = S_RRD;
      S_RRD:   state_n = S_RLINK;
      S_RLINK: state_n = S_RSP;
      S_RSP:   state_n = S_RUN;
      default: state_n = S_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_RUN;
      masked <= 1'b0;
    end else begin
      state <= state_n;
      if (start_entry)         masked <= 1'b1;
      else if (state == S_RSP) masked <= 1'b0;
    end
  end

  AST_MASK_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
    start_entry |=> masked); // R6
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (rst)
    (masked && state == S_RUN && !iret) |=> masked); // R6
  AST_UNMASK_AFTER_RET: assert property (@(posedge clk) disable iff (rst)
    (state == S_RSP) |=> !masked); // R6
endmodule

// File: rtl/irq_ctx_latch.sv
module irq_ctx_latch #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int IDW        = 4,
  parameter int WORD_BYTES = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_entry,
  input  logic           start_ret,
  input  logic [IDW-1:0] irq_id,
  input  logic [AW-1:0]  vec_base,
  input  logic [AW-1:0]  pc_cur,
  input  logic [DW-1:0]  sp_val,
  input  logic [DW-1:0]  link_val,
  output logic [DW-1:0]  sp_q,
  output logic [DW-1:0]  link_q,
  output logic [AW-1:0]  pc_q,
  output logic [AW-1:0]  vaddr_q
);
  localparam int SH = $clog2(WORD_BYTES);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q    <= '0;
      link_q  <= '0;
      pc_q    <= '0;
      vaddr_q <= '0;
    end else if (start_entry) begin
      sp_q    <= sp_val;
      link_q  <= link_val;
      pc_q    <= pc_cur;
      vaddr_q <= vec_base + (AW'(irq_id) << SH);
    end else if (start_ret) begin
      sp_q   <= sp_val;
      link_q <= link_val;
    end
  end
endmodule

// File: rtl/irq_port_drive.sv
module irq_port_drive
  import irq_seq_pkg::*;
#(
  parameter int              AW         = 32,
  parameter int              DW         = 32,
  parameter int              RFAW       = 3,
  parameter int              WORD_BYTES = 4,
  parameter logic [RFAW-1:0] SP_IDX     = 3'd5,
  parameter logic [RFAW-1:0] LINK_IDX   = 3'd6
) (
  input  seq_state_t      state,
  input  logic            boundary,
  input  logic            start_entry,
  input  logic            start_ret,
  input  logic [DW-1:0]   sp_q,
  input  logic [DW-1:0]   link_q,
  input  logic [AW-1:0]   pc_q,
  input  logic [AW-1:0]   vaddr_q,
  input  logic [DW-1:0]   mem_rdata,
  output logic            fetch_en,
  output logic            rf_we,
  output logic [RFAW-1:0] rf_waddr,
  output logic [DW-1:0]   rf_wdata,
  output logic            mem_we,
  output logic            mem_re,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            pc_we,
  output logic [AW-1:0]   pc_wdata
);
  localparam logic [DW-1:0] STEP = DW'(WORD_BYTES);

  always_comb begin
    fetch_en  = (state == S_RUN) && boundary && !start_entry && !start_ret;
    rf_we     = 1'b0;
    rf_waddr  = '0;
    rf_wdata  = '0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    pc_we     = 1'b0;
    pc_wdata  = '0;
    unique case (state)
      S_SAVE: begin
        mem_we    = 1'b1;
        mem_addr  = AW'(sp_q - STEP);
        mem_wdata = link_q;
      end
      S_ADJSP: begin
        rf_we    = 1'b1;
        rf_waddr = SP_IDX;
        rf_wdata = sp_q - STEP;
      end
      S_LINK: begin
        rf_we    = 1'b1;
        rf_waddr = LINK_IDX;
        rf_wdata = DW'(pc_q);
      end
      S_VECRD: begin
        mem_re   = 1'b1;
        mem_addr = vaddr_q;
      end
      S_VECLD: begin
        pc_we    = 1'b1;
        pc_wdata = AW'(mem_rdata);
      end
      S_RPC: begin
        pc_we    = 1'b1;
        pc_wdata = AW'(link_q);
      end
      S_RRD: begin
        mem_re   = 1'b1;
        mem_addr = AW'(sp_q);
      end
      S_RLINK: begin
        rf_we    = 1'b1;
        rf_waddr = LINK_IDX;
        rf_wdata = mem_rdata;
      end
      S_RSP: begin
        rf_we    = 1'b1;
        rf_waddr = SP_IDX;
        rf_wdata = sp_q + STEP;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int IDW        = 4,
  parameter int RFAW       = 3,
  parameter int WORD_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            boundary,
  input  logic            irq_flag,
  input  logic [IDW-1:0]  irq_id,
  input  logic [AW-1:0]   vec_base,
  input  logic [AW-1:0]   pc_cur,
  input  logic [DW-1:0]   sp_val,
  input  logic [DW-1:0]   link_val,
  input  logic            iret,
  input  logic [DW-1:0]   mem_rdata,
  output logic            fetch_en,
  output logic            rf_we,
  output logic [RFAW-1:0] rf_waddr,
  output logic [DW-1:0]   rf_wdata,
  output logic            mem_we,
  output logic            mem_re,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            pc_we,
  output logic [AW-1:0]   pc_wdata
);
  localparam logic [RFAW-1:0] SP_IDX   = RFAW'(5);
  localparam logic [RFAW-1:0] LINK_IDX = RFAW'(6);

  seq_state_t    state;
  logic          masked;
  logic          start_entry;
  logic          start_ret;
  logic [DW-1:0] sp_q;
  logic [DW-1:0] link_q;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] vaddr_q;

  irq_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .boundary(boundary), .irq_flag(irq_flag), .iret(iret),
    .state(state), .masked(masked), .start_entry(start_entry), .start_ret(start_ret)
  );

  irq_ctx_latch #(.AW(AW), .DW(DW), .IDW(IDW), .WORD_BYTES(WORD_BYTES)) u_ctx (
    .clk(clk), .rst(rst), .start_entry(start_entry), .start_ret(start_ret),
    .irq_id(irq_id), .vec_base(vec_base), .pc_cur(pc_cur), .sp_val(sp_val),
    .link_val(link_val), .sp_q(sp_q), .link_q(link_q), .pc_q(pc_q), .vaddr_q(vaddr_q)
  );

  irq_port_drive #(
    .AW(AW), .DW(DW), .RFAW(RFAW), .WORD_BYTES(WORD_BYTES),
    .SP_IDX(SP_IDX), .LINK_IDX(LINK_IDX)
  ) u_drv (
    .state(state), .boundary(boundary), .start_entry(start_entry), .start_ret(start_ret),
    .sp_q(sp_q), .link_q(link_q), .pc_q(pc_q), .vaddr_q(vaddr_q), .mem_rdata(mem_rdata),
    .fetch_en(fetch_en), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .pc_we(pc_we), .pc_wdata(pc_wdata)
  );

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_we, mem_re, rf_we, pc_we})); // R10
  AST_FETCH_QUIET: assert property (@(posedge clk) disable iff (rst)
    fetch_en |-> !(mem_we || mem_re || rf_we || pc_we)); // R1
  AST_ENTRY_SAVE: assert property (@(posedge clk) disable iff (rst)
    start_entry |=> (mem_we && mem_wdata == $past(link_val)
                     && mem_addr == AW'($past(sp_val) - DW'(WORD_BYTES)))); // R2
  AST_SAVE_TO_SP: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (rf_we && rf_waddr == SP_IDX)); // R3
  AST_SP_TO_LINK: assert property (@(posedge clk) disable iff (rst)
    (rf_we && rf_waddr == SP_IDX && $past(mem_we)) |=> (rf_we && rf_waddr == LINK_IDX)); // R4
  AST_VEC_TO_PC: assert property (@(posedge clk) disable iff (rst)
    (mem_re && !$past(pc_we)) |=> (pc_we && pc_wdata == AW'(mem_rdata))); // R5
  AST_IRET_PC: assert property (@(posedge clk) disable iff (rst)
    start_ret |=> (pc_we && pc_wdata == AW'($past(link_val)))); // R7
endmodule

// File: tb/tb_irq_entry_seq.sv
`timescale 1ns/1ps
module tb_irq_entry_seq;
  localparam int AW = 32;
  localparam int DW = 32;

  typedef struct packed {
    logic [3:0]  id;
    logic [31:0] base;
    logic [31:0] sp;
    logic [31:0] link;
    logic [31:0] pc;
  } vec_t;

  // id, table base, stack pointer, link value, program counter
  localparam vec_t VECS [4] = '{
    '{4'd0,  32'h000, 32'h3F0, 32'hAAAA0001, 32'h1000},
    '{4'd15, 32'h080, 32'h380, 32'h12345678, 32'h2004},
    '{4'd7,  32'h080, 32'h340, 32'h00000000, 32'hFFFC},
    '{4'd9,  32'h000, 32'h2F8, 32'hCAFEF00D, 32'h0008}
  };
  localparam int ZERO_SLOT = 32'h080 / 4 + 7;

  logic clk = 1'b0, rst = 1'b1;
  logic boundary = 1'b0, irq_flag = 1'b0, iret = 1'b0;
  logic [3:0] irq_id = '0;
  logic [AW-1:0] vec_base = '0, pc_cur = '0;
  logic [DW-1:0] sp_val = '0, link_val = '0, mem_rdata = '0;
  logic fetch_en, rf_we, mem_we, mem_re, pc_we;
  logic [2:0] rf_waddr;
  logic [DW-1:0] rf_wdata, mem_wdata;
  logic [AW-1:0] mem_addr, pc_wdata;
  logic [31:0] mem [256];
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rst(rst), .boundary(boundary), .irq_flag(irq_flag), .irq_id(irq_id),
    .vec_base(vec_base), .pc_cur(pc_cur), .sp_val(sp_val), .link_val(link_val),
    .iret(iret), .mem_rdata(mem_rdata), .fetch_en(fetch_en), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pc_we(pc_we), .pc_wdata(pc_wdata)
  );

  function automatic logic [31:0] vec_val(input int slot);
    return (slot == ZERO_SLOT) ? 32'h0 : 32'h4000 + 32'(slot) * 32'h100;
  endfunction

  // synchronous RAM model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[9:2]];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic run_entry(input vec_t v);
    @(negedge clk);
    boundary = 1; irq_flag = 1; irq_id = v.id; vec_base = v.base;
    sp_val = v.sp; link_val = v.link; pc_cur = v.pc;
    #1 chk("R1 fetch held at entry", 32'(fetch_en), 0);
    step();
    irq_flag = 0; sp_val = 32'hDEAD; link_val = 32'hBEEF; pc_cur = 32'h7777;
    #1;
    chk("R2 save strobe", 32'(mem_we), 1);
    chk("R2 save addr", mem_addr, v.sp - 4);
    chk("R2 save data", mem_wdata, v.link);
    chk("R1 no fetch in sequence", 32'(fetch_en), 0);
    step();
    chk("R3 sp write", {rf_we, rf_waddr, rf_wdata[27:0]}, {1'b1, 3'd5, 28'(v.sp - 4)});
    step();
    chk("R4 link write", {rf_we, rf_waddr, rf_wdata[27:0]}, {1'b1, 3'd6, v.pc[27:0]});
    step();
    chk("R5 vector read", {mem_re, mem_addr[30:0]}, {1'b1, 31'(v.base + 32'(v.id) * 4)});
    step();
    chk("R5 pc load strobe", 32'(pc_we), 1);
    chk("R5 pc load value", pc_wdata, vec_val(int'((v.base + 32'(v.id) * 4) >> 2)));
    chk("R10 one strobe", 32'($countones({mem_we, mem_re, rf_we, pc_we})), 1);
    step();
    chk("R1 fetch after entry", 32'(fetch_en), 1);
    boundary = 0;
  endtask

  task automatic run_return(input logic [31:0] sp_now, input logic [31:0] lk,
                            input logic [31:0] saved);
    @(negedge clk);
    iret = 1; sp_val = sp_now; link_val = lk;
    step();
    iret = 0; sp_val = 32'h1111; link_val = 32'h2222;
    chk("R7 pc restore", {31'(pc_wdata), pc_we}, {31'(lk), 1'b1});
    step();
    chk("R7 stack read", {mem_re, mem_addr[30:0]}, {1'b1, 31'(sp_now)});
    step();
    chk("R7 link reload", {rf_we, rf_waddr, rf_wdata[27:0]}, {1'b1, 3'd6, saved[27:0]});
    step();
    chk("R7 sp release", {rf_we, rf_waddr, rf_wdata[27:0]}, {1'b1, 3'd5, 28'(sp_now + 4)});
    step();
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = vec_val(i);
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset strobes", 32'({fetch_en, mem_we, mem_re, rf_we, pc_we}), 0);
    rst = 0;
    step();
    boundary = 1; #1;
    chk("R9 unmasked fetch after reset", 32'(fetch_en), 1);
    boundary = 0;

    // R11: request without boundary
    irq_flag = 1;
    step();
    step();
    chk("R11 no action off boundary", 32'({mem_we, mem_re, rf_we, pc_we, fetch_en}), 0);
    irq_flag = 0;

    // main table
    for (int k = 0; k < 4; k++) begin
      run_entry(VECS[k]);
      run_return(VECS[k].sp - 4, VECS[k].pc, VECS[k].link);
    end

    // R6: masked request is held off, then taken after return
    run_entry(VECS[1]);
    @(negedge clk);
    boundary = 1; irq_flag = 1;
    #1 chk("R6 fetch while masked", 32'(fetch_en), 1);
    step();
    chk("R6 no entry while masked", 32'({mem_we, rf_we}), 0);
    boundary = 0;
    run_return(VECS[1].sp - 4, VECS[1].pc, VECS[1].link);
    boundary = 1; #1;
    chk("R6 pending taken", 32'(fetch_en), 0);
    step();
    chk("R6 pending entry save", 32'(mem_we), 1);
    boundary = 0; irq_flag = 0;
    repeat (4) step();
    run_return(VECS[1].sp - 4, 32'h40, VECS[1].link);

    // R8: iret and takeable request together
    @(negedge clk);
    boundary = 1; irq_flag = 1; iret = 1; sp_val = 32'h200; link_val = 32'h5550;
    step();
    iret = 0; irq_flag = 0; boundary = 0;
    chk("R8 return wins", {30'(pc_wdata), pc_we, mem_we}, {30'h5550, 1'b1, 1'b0});
    repeat (4) step();
    boundary = 1; #1;
    chk("R8 idle afterwards", 32'(fetch_en), 1);
    boundary = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule